// File: doc/BRIEF.md
# Micro-TLB with Deferred Invalidation

This block is a small, fully associative translation cache that sits beside a larger main TLB. It holds the entries the core has used most recently. A lookup presents a virtual page number and an address-space identifier. One clock later the block reports either a hit with the physical page number, or a miss that carries the looked-up tag so the main TLB can answer with a fill. Entries for fills are chosen by taking empty slots first and, once every slot is full, by a rotating pointer.

The block does not follow the main TLB's contents. Instead it watches the command stream sent to the main TLB. An ordinary main-TLB write empties the whole micro-TLB. A write variant that preserves the micro-TLB leaves it as it is. A dedicated command empties it explicitly. Because of this, a translation that the main TLB has already displaced can still be served here until one of the clearing commands arrives. That lets the micro-TLB's full associativity hide conflict misses in the main array.

The default configuration (8 entries) suits the data side. A second instance with `N_ENT = 4` serves the instruction side.

Top module: `utlb`

## Requirements
- R1: While reset is high and in the first cycle after it, `hit` and `miss` are low and every entry is invalid, so the first lookup after reset misses.
- R2: A lookup is sampled at a rising edge and its result appears on the registered outputs right after that edge. Exactly one of `hit`/`miss` is high for a lookup. A hit drives the stored page number on `hit_pfn`. In a cycle with no lookup, both flags are low.
- R3: An entry matches only when both its page number and its identifier equal the lookup's. A difference in either one gives a miss.
- R4: On a miss, `miss_vpn` and `miss_asid` carry the looked-up tag in the same cycle that `miss` is high.
- R5: A fill sampled at one rising edge is installed at the next rising edge. A lookup sampled at that next edge still misses; a lookup sampled one edge later hits.
- R6: A command with `mcmd_op` = 1 (ordinary main write) invalidates every entry.
- R7: A command with `mcmd_op` = 2 (write that keeps the micro-TLB) changes nothing. Entries stay valid and keep hitting, even though the main TLB may no longer hold them.
- R8: A command with `mcmd_op` = 3 invalidates every entry. It needs no other condition, including after a probe (`mcmd_op` = 4) that found nothing. Codes 0, 4, 5, 6 and 7 have no effect.
- R9: A fill whose tag is not present goes to the lowest-numbered invalid slot while any slot is invalid.
- R10: When all slots are valid, a fill replaces the slot named by a rotating pointer. The pointer is 0 after reset and moves to the next slot after each such replacement. Invalidation does not reset it.
- R11: A fill whose tag is already present overwrites that entry's page number in place. It evicts nothing, does not move the pointer, and never creates two matching entries.
- R12: A clearing command in the same cycle as an install discards the fill. A lookup in the same cycle as a clearing command sees the contents from before the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asid | input | ASID_W | Lookup address-space identifier |
| hit | output | 1 | Registered hit flag |
| hit_pfn | output | PFN_W | Physical page number of the hit |
| miss | output | 1 | Registered miss flag / fill request |
| miss_vpn | output | VPN_W | Page number that missed |
| miss_asid | output | ASID_W | Identifier that missed |
| fill_valid | input | 1 | Fill response from the main TLB |
| fill_vpn | input | VPN_W | Fill page number |
| fill_asid | input | ASID_W | Fill identifier |
| fill_pfn | input | PFN_W | Fill physical page number |
| mcmd_valid | input | 1 | Main-TLB command strobe |
| mcmd_op | input | 3 | Main-TLB command code |

## Verification
The hardest state to reach is a full array whose rotating pointer is not at zero and which has just been emptied by a command. Only that state shows that empty slots are preferred over the pointer and that the pointer survives the clear. The stimulus overfills the array twice to move the pointer to slot 2, clears it, refills all slots, and then checks which tag a ninth fill displaces. The same-cycle races also need exact timing: the stimulus places a clearing command in the one cycle between fill capture and install, and in the same cycle as a lookup.

// File: rtl/utlb_pkg.sv
package utlb_pkg;

  typedef enum logic [2:0] {
    MOP_IDLE       = 3'd0,
    MOP_WRITE      = 3'd1,
    MOP_WRITE_KEEP = 3'd2,
    MOP_UFLUSH     = 3'd3,
    MOP_PROBE      = 3'd4,
    MOP_READ       = 3'd5,
    MOP_GETIDX     = 3'd6,
    MOP_RSVD       = 3'd7
  } mop_e;

  // True for the main-TLB commands that empty the micro-TLB.
  function automatic logic mop_clears(input logic [2:0] op);
    return (op == MOP_WRITE) || (op == MOP_UFLUSH);
  endfunction

endpackage

// File: rtl/utlb_cmd_dec.sv
module utlb_cmd_dec
  import utlb_pkg::*;
(
  input  logic       mcmd_valid,
  input  logic [2:0] mcmd_op,
  output logic       clr_all
);

  // The explicit flush depends on the command code alone; no index state gates it.
  always_comb begin
    clr_all = mcmd_valid && mop_clears(mcmd_op);
  end

endmodule

// File: rtl/utlb_tag_cam.sv
module utlb_tag_cam #(
  parameter int N_ENT  = 8,
  parameter int VPN_W  = 19,
  parameter int ASID_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     wr_en,
  input  logic [$clog2(N_ENT)-1:0] wr_idx,
  input  logic [VPN_W-1:0]         wr_vpn,
  input  logic [ASID_W-1:0]        wr_asid,
  input  logic [VPN_W-1:0]         lk_vpn,
  input  logic [ASID_W-1:0]        lk_asid,
  input  logic [VPN_W-1:0]         cmp_vpn,
  input  logic [ASID_W-1:0]        cmp_asid,
  output logic [N_ENT-1:0]         ent_valid,
  output logic [N_ENT-1:0]         lk_vec,
  output logic [N_ENT-1:0]         cmp_vec
);

  logic [VPN_W-1:0]  vpn_q  [N_ENT];
  logic [ASID_W-1:0] asid_q [N_ENT];

  // Valid bits: a flush outranks a write.
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ent_valid <= '0;
    end else if (wr_en) begin
      ent_valid[wr_idx] <= 1'b1;
    end
  end

  // Tag storage, no reset needed.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      vpn_q[wr_idx]  <= wr_vpn;
      asid_q[wr_idx] <= wr_asid;
    end
  end

  // Two compare ports: one for lookups, one for the fill being installed.
  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign lk_vec[g]  = ent_valid[g] && (vpn_q[g] == lk_vpn)  && (asid_q[g] == lk_asid);
    assign cmp_vec[g] = ent_valid[g] && (vpn_q[g] == cmp_vpn) && (asid_q[g] == cmp_asid);
  end

endmodule

// File: rtl/utlb_victim.sv
module utlb_victim #(
  parameter int N_ENT = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_ENT-1:0]         ent_valid,
  input  logic [N_ENT-1:0]         dup_vec,
  input  logic                     ins_en,
  output logic [$clog2(N_ENT)-1:0] ins_idx
);

  localparam int IW = $clog2(N_ENT);

  logic [IW-1:0] rr_q;
  logic [IW-1:0] free_idx;
  logic [IW-1:0] dup_idx;
  logic          all_full;
  logic          has_dup;

  assign all_full = &ent_valid;
  assign has_dup  = |dup_vec;

  // Lowest free slot, and the slot already holding the fill's tag.
  always_comb begin
    free_idx = '0;
    dup_idx  = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (!ent_valid[i]) free_idx = IW'(i);
      if (dup_vec[i])    dup_idx  = IW'(i);
    end
  end

  // Priority: same-tag entry first, then an empty slot, then the rotating pointer.
  always_comb begin
    if (has_dup)       ins_idx = dup_idx;
    else if (!all_full) ins_idx = free_idx;
    else               ins_idx = rr_q;
  end

  // The pointer moves only on a true replacement and survives flushes.
  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (ins_en && all_full && !has_dup) begin
      rr_q <= (rr_q == IW'(N_ENT - 1)) ? '0 : rr_q + 1'b1;
    end
  end

endmodule

// File: rtl/utlb.sv
module utlb
  import utlb_pkg::*;
#(
  parameter int N_ENT  = 8,
  parameter int VPN_W  = 19,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              hit,
  output logic [PFN_W-1:0]  hit_pfn,
  output logic              miss,
  output logic [VPN_W-1:0]  miss_vpn,
  output logic [ASID_W-1:0] miss_asid,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic              mcmd_valid,
  input  logic [2:0]        mcmd_op
);

  localparam int IW = $clog2(N_ENT);

  logic              clr_all;
  logic              stg_valid;
  logic [VPN_W-1:0]  stg_vpn;
  logic [ASID_W-1:0] stg_asid;
  logic [PFN_W-1:0]  stg_pfn;
  logic              ins_en;
  logic [IW-1:0]     ins_idx;
  logic [N_ENT-1:0]  ent_valid;
  logic [N_ENT-1:0]  lk_match;
  logic [N_ENT-1:0]  cmp_match;
  logic [IW-1:0]     lk_idx;
  logic              lk_any;
  logic [PFN_W-1:0]  pfn_mem [N_ENT];

  utlb_cmd_dec u_dec (
    .mcmd_valid (mcmd_valid),
    .mcmd_op    (mcmd_op),
    .clr_all    (clr_all)
  );

  // Fill staging: the response is captured, then installed one edge later.
  always_ff @(posedge clk) begin
    if (rst) stg_valid <= 1'b0;
    else     stg_valid <= fill_valid;
  end

  always_ff @(posedge clk) begin
    if (fill_valid) begin
      stg_vpn  <= fill_vpn;
      stg_asid <= fill_asid;
      stg_pfn  <= fill_pfn;
    end
  end

  // A flush in the install cycle discards the fill.
  assign ins_en = stg_valid && !clr_all;

  utlb_tag_cam #(
    .N_ENT  (N_ENT),
    .VPN_W  (VPN_W),
    .ASID_W (ASID_W)
  ) u_cam (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr_all),
    .wr_en     (ins_en),
    .wr_idx    (ins_idx),
    .wr_vpn    (stg_vpn),
    .wr_asid   (stg_asid),
    .lk_vpn    (lk_vpn),
    .lk_asid   (lk_asid),
    .cmp_vpn   (stg_vpn),
    .cmp_asid  (stg_asid),
    .ent_valid (ent_valid),
    .lk_vec    (lk_match),
    .cmp_vec   (cmp_match)
  );

  utlb_victim #(
    .N_ENT (N_ENT)
  ) u_vic (
    .clk       (clk),
    .rst       (rst),
    .ent_valid (ent_valid),
    .dup_vec   (cmp_match),
    .ins_en    (ins_en),
    .ins_idx   (ins_idx)
  );

  // Encode the lookup match into a read address.
  always_comb begin
    lk_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (lk_match[i]) lk_idx = IW'(i);
    end
  end

  assign lk_any = |lk_match;

  // Page-number array: one write port, one registered read port.
  always_ff @(posedge clk) begin
    if (ins_en) pfn_mem[ins_idx] <= stg_pfn;
    hit_pfn <= pfn_mem[lk_idx];
  end

  // Registered result flags and the fill request tag.
  always_ff @(posedge clk) begin
    if (rst) begin
      hit  <= 1'b0;
      miss <= 1'b0;
    end else begin
      hit  <= lk_valid && lk_any;
      miss <= lk_valid && !lk_any;
    end
  end

  always_ff @(posedge clk) begin
    if (lk_valid && !lk_any) begin
      miss_vpn  <= lk_vpn;
      miss_asid <= lk_asid;
    end
  end

endmodule

// File: rtl/utlb_chk.sv
module utlb_chk
  import utlb_pkg::*;
#(
  parameter int N_ENT = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     lk_valid,
  input logic                     mcmd_valid,
  input logic [2:0]               mcmd_op,
  input logic                     hit,
  input logic                     miss,
  input logic [N_ENT-1:0]         ent_valid,
  input logic [N_ENT-1:0]         lk_match,
  input logic [N_ENT-1:0]         cmp_match,
  input logic                     ins_en,
  input logic [$clog2(N_ENT)-1:0] ins_idx
);

  p_hit_miss_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(hit && miss));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> (!hit && !miss));

  p_write_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (mcmd_valid && mcmd_op == MOP_WRITE) |=> (ent_valid == '0));

  p_keep_write_r7: assert property (@(posedge clk) disable iff (rst)
    (mcmd_valid && mcmd_op == MOP_WRITE_KEEP && !ins_en) |=> $stable(ent_valid));

  p_uflush_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (mcmd_valid && mcmd_op == MOP_UFLUSH) |=> (ent_valid == '0));

  p_free_first_r9: assert property (@(posedge clk) disable iff (rst)
    (ins_en && !(&ent_valid) && !(|cmp_match)) |-> !ent_valid[ins_idx]);

  p_no_dup_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_match));

  p_one_install_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(ent_valid) <= $countones($past(ent_valid)) + 1));

endmodule

bind utlb utlb_chk #(.N_ENT(N_ENT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .lk_valid   (lk_valid),
  .mcmd_valid (mcmd_valid),
  .mcmd_op    (mcmd_op),
  .hit        (hit),
  .miss       (miss),
  .ent_valid  (ent_valid),
  .lk_match   (lk_match),
  .cmp_match  (cmp_match),
  .ins_en     (ins_en),
  .ins_idx    (ins_idx)
);

// File: tb/utlb_tb.sv
`timescale 1ns/1ps
module utlb_tb;
  localparam int VW = 19, AW = 8, PW = 19;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          lk_valid = 1'b0;
  logic [VW-1:0] lk_vpn = '0;
  logic [AW-1:0] lk_asid = '0;
  logic          hit, miss;
  logic [PW-1:0] hit_pfn;
  logic [VW-1:0] miss_vpn;
  logic [AW-1:0] miss_asid;
  logic          fill_valid = 1'b0;
  logic [VW-1:0] fill_vpn = '0;
  logic [AW-1:0] fill_asid = '0;
  logic [PW-1:0] fill_pfn = '0;
  logic          mcmd_valid = 1'b0;
  logic [2:0]    mcmd_op = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic          r_hit, r_miss;
  logic [PW-1:0] r_pfn;
  logic [VW-1:0] r_mvpn;
  logic [AW-1:0] r_masid;

  always #2.5 clk = ~clk;

  utlb u_dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .hit(hit), .hit_pfn(hit_pfn), .miss(miss), .miss_vpn(miss_vpn), .miss_asid(miss_asid),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_pfn(fill_pfn),
    .mcmd_valid(mcmd_valid), .mcmd_op(mcmd_op)
  );

  function automatic logic [PW-1:0] pf(input logic [VW-1:0] v);
    return PW'(v * 3 + 7);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Drive a lookup, sample the registered result 1 ns after the edge.
  task automatic look(input logic [VW-1:0] v, input logic [AW-1:0] a);
    lk_valid = 1'b1; lk_vpn = v; lk_asid = a;
    @(posedge clk); #1;
    r_hit = hit; r_miss = miss; r_pfn = hit_pfn; r_mvpn = miss_vpn; r_masid = miss_asid;
    lk_valid = 1'b0;
  endtask

  task automatic fill(input logic [VW-1:0] v, input logic [AW-1:0] a, input logic [PW-1:0] p);
    fill_valid = 1'b1; fill_vpn = v; fill_asid = a; fill_pfn = p;
    @(posedge clk); #1;
    fill_valid = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic cmd(input logic [2:0] op);
    mcmd_valid = 1'b1; mcmd_op = op;
    @(posedge clk); #1;
    mcmd_valid = 1'b0;
  endtask

  task automatic expect_look(input logic [VW-1:0] v, input logic [AW-1:0] a,
                             input bit eh, input logic [PW-1:0] ep, input string req);
    look(v, a);
    chk(r_hit == eh, req, "hit", r_hit, eh);
    chk(r_miss == !eh, req, "miss", r_miss, !eh);
    if (eh) chk(r_pfn == ep, req, "pfn", r_pfn, ep);
  endtask

  task automatic t_reset();
    chk(hit == 0 && miss == 0, "R1", "flags in reset", {hit, miss}, 0);
    @(posedge clk); #1; rst = 1'b0;
    chk(hit == 0 && miss == 0, "R1", "flags after reset", {hit, miss}, 0);
    expect_look(19'h0, 8'h0, 0, '0, "R1");
    @(posedge clk); #1;
    chk(hit == 0 && miss == 0, "R2", "idle flags", {hit, miss}, 0);
  endtask

  task automatic t_match();
    fill(19'h100, 8'h01, pf(19'h100));
    expect_look(19'h100, 8'h01, 1, pf(19'h100), "R2");
    expect_look(19'h100, 8'h02, 0, '0, "R3");
    chk(r_mvpn == 19'h100 && r_masid == 8'h02, "R4", "miss tag", {r_mvpn, r_masid}, {19'h100, 8'h02});
    expect_look(19'h101, 8'h01, 0, '0, "R3");
    chk(r_mvpn == 19'h101, "R4", "miss vpn", r_mvpn, 19'h101);
  endtask

  task automatic t_fill_timing();
    fill_valid = 1'b1; fill_vpn = 19'h200; fill_asid = 8'h03; fill_pfn = pf(19'h200);
    @(posedge clk); #1;
    fill_valid = 1'b0;
    look(19'h200, 8'h03);
    chk(r_miss == 1 && r_hit == 0, "R5", "lookup at install edge", r_hit, 0);
    expect_look(19'h200, 8'h03, 1, pf(19'h200), "R5");
  endtask

  task automatic t_cmds();
    cmd(3'd3);
    fill(19'h300, 8'h04, pf(19'h300));
    cmd(3'd2);
    expect_look(19'h300, 8'h04, 1, pf(19'h300), "R7");
    cmd(3'd0); cmd(3'd5); cmd(3'd6); cmd(3'd7);
    expect_look(19'h300, 8'h04, 1, pf(19'h300), "R8");
    cmd(3'd1);
    expect_look(19'h300, 8'h04, 0, '0, "R6");
    fill(19'h300, 8'h04, pf(19'h300));
    look(19'h777, 8'h04);
    cmd(3'd4);
    expect_look(19'h300, 8'h04, 1, pf(19'h300), "R8");
    cmd(3'd3);
    expect_look(19'h300, 8'h04, 0, '0, "R8");
  endtask

  task automatic t_replace();
    cmd(3'd3);
    for (int i = 0; i < 8; i++) fill(VW'(19'h400 + i), 8'h05, pf(VW'(19'h400 + i)));
    for (int i = 0; i < 8; i++) expect_look(VW'(19'h400 + i), 8'h05, 1, pf(VW'(19'h400 + i)), "R9");
    fill(19'h408, 8'h05, pf(19'h408));
    expect_look(19'h400, 8'h05, 0, '0, "R10");
    expect_look(19'h401, 8'h05, 1, pf(19'h401), "R10");
    expect_look(19'h408, 8'h05, 1, pf(19'h408), "R10");
    fill(19'h409, 8'h05, pf(19'h409));
    expect_look(19'h401, 8'h05, 0, '0, "R10");
    expect_look(19'h402, 8'h05, 1, pf(19'h402), "R10");
    cmd(3'd3);
    for (int i = 0; i < 8; i++) fill(VW'(19'h500 + i), 8'h06, pf(VW'(19'h500 + i)));
    for (int i = 0; i < 8; i++) expect_look(VW'(19'h500 + i), 8'h06, 1, pf(VW'(19'h500 + i)), "R9");
    fill(19'h508, 8'h06, pf(19'h508));
    expect_look(19'h502, 8'h06, 0, '0, "R10");
    expect_look(19'h500, 8'h06, 1, pf(19'h500), "R10");
    expect_look(19'h503, 8'h06, 1, pf(19'h503), "R10");
  endtask

  task automatic t_dup();
    cmd(3'd3);
    for (int i = 0; i < 8; i++) fill(VW'(19'h600 + i), 8'h07, pf(VW'(19'h600 + i)));
    fill(19'h605, 8'h07, 19'h1abcd);
    expect_look(19'h605, 8'h07, 1, 19'h1abcd, "R11");
    for (int i = 0; i < 8; i++)
      if (i != 5) expect_look(VW'(19'h600 + i), 8'h07, 1, pf(VW'(19'h600 + i)), "R11");
    fill(19'h608, 8'h07, pf(19'h608));
    expect_look(19'h603, 8'h07, 0, '0, "R11");
    expect_look(19'h604, 8'h07, 1, pf(19'h604), "R11");
  endtask

  task automatic t_race();
    cmd(3'd3);
    fill(19'h700, 8'h08, pf(19'h700));
    fill_valid = 1'b1; fill_vpn = 19'h701; fill_asid = 8'h08; fill_pfn = pf(19'h701);
    @(posedge clk); #1;
    fill_valid = 1'b0;
    cmd(3'd3);
    expect_look(19'h701, 8'h08, 0, '0, "R12");
    expect_look(19'h700, 8'h08, 0, '0, "R12");
    fill(19'h702, 8'h08, pf(19'h702));
    mcmd_valid = 1'b1; mcmd_op = 3'd1;
    look(19'h702, 8'h08);
    mcmd_valid = 1'b0;
    chk(r_hit == 1 && r_pfn == pf(19'h702), "R12", "lookup beside clear", r_hit, 1);
    expect_look(19'h702, 8'h08, 0, '0, "R12");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_match();
    t_fill_timing();
    t_cmds();
    t_replace();
    t_dup();
    t_race();
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule